// File: doc/BRIEF.md
# Prescaled Up-Counter with Reference Match

This block is a 16-bit up-counting timer that software programs through a small word-wide register window. A two-stage prescaler slows the system clock down: an optional fixed divide-by-16 stage followed by a programmable divider whose divisor is an 8-bit field plus one. Each prescaler tick moves the counter up by one. When the counter reaches the programmed reference value, a sticky event flag is set. That flag drives the interrupt line when the interrupt enable bit is set.

Software starts the timer by writing the control word. It selects the tick source, the divisor, whether the count returns to zero after a match, and whether a match raises the interrupt. The current count can be read at any time and overwritten at any time. The event flag is cleared by writing a one to its bit position. Any write to the control word or to the reference register starts counting again from zero with a fresh prescaler phase.

Top module: `ref_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. Register addresses are: 0 control, 1 reference, 2 capture, 3 count, 4 event.
- R2: While control bit 0 (enable) is clear, the count reads zero. This holds regardless of elapsed cycles and of writes to the count register.
- R3: With enable set and control bits 2:1 equal to 1, the count rises by one every (P+1) cycles, where P is control bits 15:8. With bits 2:1 equal to 2, it rises by one every 16*(P+1) cycles.
- R4: With enable set and control bits 2:1 equal to 0 or 3, the count does not advance.
- R5: With control bit 3 set, the tick that finds the count equal to the reference value returns the count to zero. With bit 3 clear, the count continues past the reference value and wraps only after 0xFFFF.
- R6: Event register bit 1 is set when a tick makes the count equal to the reference value. Event bit 0 and bits 15:2 read zero.
- R7: `irq` is high exactly when control bit 4 and event bit 1 are both set, one cycle after the edge that set the later of the two.
- R8: A write to the event register clears bit 1 if the written bit 1 is one and leaves it unchanged otherwise. A match in the same cycle keeps the bit set.
- R9: A write to the count register while enabled loads the written value, and counting continues from it at the existing prescaler phase.
- R10: A write to the control or reference register clears the count to zero and restarts the prescaler phase.
- R11: A control write that changes bit 0 from one to zero also clears the reference register. A control write with bit 0 clear while already disabled leaves the reference register unchanged.
- R12: The capture register and the unused addresses 5 to 7 read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address, used for both reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the register at `addr`, combinational |
| irq | output | 1 | Reference-match interrupt |

## Verification
Every register update, including count steps, loads, restarts, flag sets and flag clears, takes effect at the clock edge that samples the write or the tick. Its value is therefore due in the cycle after that edge. Read data follows `addr` combinationally within the same cycle. `irq` follows the flag and the enable bit with no extra register. The bench keeps a behavioural model that advances on the same edge, from the inputs held stable across it. It compares `rdata` and `irq` against that model late in every cycle, well after the falling-edge input changes have settled and before the next rising edge. As a result, each expected value lands on exactly the cycle in which it is due.

// File: rtl/ref_timer_pkg.sv
// Shared definitions for the reference-match timer: register addresses,
// control and event field positions, and the tick-source encoding.
package ref_timer_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_REFV  = 3'd1,
        A_CAPT  = 3'd2,
        A_COUNT = 3'd3,
        A_EVENT = 3'd4
    } reg_addr_e;

    localparam int unsigned B_EN      = 0;
    localparam int unsigned B_SRC_LO  = 1;
    localparam int unsigned B_WRAP    = 3;
    localparam int unsigned B_IRQ_EN  = 4;
    localparam int unsigned B_DIV_LO  = 8;
    localparam int unsigned B_EV_REF  = 1;

    typedef enum logic [1:0] {
        SRC_NONE0 = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_SYS16 = 2'd2,
        SRC_NONE3 = 2'd3
    } tick_src_e;

endpackage

// File: rtl/rt_prescaler.sv
// Two-stage tick generator. An optional fixed divide-by-2**SUB_W stage
// feeds a programmable divider of (div+1). Assumes div and use_sub change
// only together with a restart, so a phase is never cut short by a new limit.
module rt_prescaler #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             use_sub,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};

    logic [SUB_W-1:0] sub_q;
    logic [DIV_W-1:0] div_q;
    logic             sub_ok;

    assign sub_ok = !use_sub || (sub_q == SUB_LAST);
    assign tick   = run && !restart && sub_ok && (div_q == div);

    // Fixed sub-divider: free-running while the timer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            sub_q <= '0;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // Programmable divider: steps on each sub-divider terminal cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            div_q <= '0;
        end else if (sub_ok) begin
            div_q <= (div_q == div) ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/rt_counter.sv
// Timer count register with load, restart, and optional return-to-zero
// after the reference value. Flags a match when a tick makes the count
// equal to the reference.
module rt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         wrap_en,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] cnt_q,
    output logic         match
);
    logic [W-1:0] nxt;

    assign nxt   = (wrap_en && (cnt_q == ref_val)) ? '0 : cnt_q + 1'b1;
    assign match = en && !clear && !load && tick && (nxt == ref_val);

    // Count update in priority order: disable, restart, load, tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= nxt;
        end
    end

endmodule

// File: rtl/rt_events.sv
// Sticky reference-match flag. Write-one clears it, and a set in the same
// cycle takes precedence over the clear.
module rt_events (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ref,
    input  logic clr_ref,
    output logic ref_q
);
    // Flag update: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= (ref_q && !clr_ref) || set_ref;
        end
    end

endmodule

// File: rtl/ref_timer.sv
// Prescaled 16-bit up-counter with reference match and interrupt.
// Holds the control and reference registers, decodes writes, muxes reads.
// Assumes B_DIV_LO + DIV_W <= DATA_W.
module ref_timer
    import ref_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned SUB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] cnt_q;
    logic              evt_ref;
    logic              tick;
    logic              match_pulse;
    logic              wr_ctrl, wr_refv, wr_count, wr_event;
    logic              restart, run;
    tick_src_e         src;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_refv  = wr_en && (addr == A_REFV);
    assign wr_count = wr_en && (addr == A_COUNT);
    assign wr_event = wr_en && (addr == A_EVENT);
    assign restart  = wr_ctrl || wr_refv;
    assign src      = tick_src_e'(mode_q[B_SRC_LO +: 2]);
    assign run      = mode_q[B_EN] && ((src == SRC_SYS) || (src == SRC_SYS16));

    // Control register: takes every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_ctrl) begin
            mode_q <= wdata;
        end
    end

    // Reference register: cleared when the timer is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (wr_ctrl && mode_q[B_EN] && !wdata[B_EN]) begin
            ref_q <= '0;
        end else if (wr_refv) begin
            ref_q <= wdata;
        end
    end

    rt_prescaler #(.DIV_W(DIV_W), .SUB_W(SUB_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .use_sub (src == SRC_SYS16),
        .div     (mode_q[B_DIV_LO +: DIV_W]),
        .tick    (tick)
    );

    rt_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_q[B_EN]),
        .clear    (restart),
        .load     (wr_count),
        .load_val (wdata),
        .tick     (tick),
        .wrap_en  (mode_q[B_WRAP]),
        .ref_val  (ref_q),
        .cnt_q    (cnt_q),
        .match    (match_pulse)
    );

    rt_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ref (match_pulse),
        .clr_ref (wr_event && wdata[B_EV_REF]),
        .ref_q   (evt_ref)
    );

    // Read mux: unmapped and capture addresses return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = mode_q;
            A_REFV:  rdata = ref_q;
            A_COUNT: rdata = cnt_q;
            A_EVENT: rdata[B_EV_REF] = evt_ref;
            default: rdata = '0;
        endcase
    end

    assign irq = mode_q[B_IRQ_EN] && evt_ref;

endmodule

// File: rtl/rt_checker.sv
// Temporal checks on the timer, bound into every ref_timer instance.
module rt_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] ref_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              evt_ref,
    input logic              tick,
    input logic              match_pulse
);
    logic wr_cnt, rst_wr;
    assign wr_cnt = wr_en && (addr == 3'd3);
    assign rst_wr = wr_en && ((addr == 3'd0) || (addr == 3'd1));

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0] |=> (cnt_q == '0));                                       // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && !tick && !wr_cnt && !rst_wr) |=> $stable(cnt_q));      // R3
    AST_NO_SRC_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2:1] == 2'd0 || mode_q[2:1] == 2'd3) |-> !tick);             // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && mode_q[3] && tick && !wr_cnt && !rst_wr && cnt_q == ref_q)
        |=> (cnt_q == '0));                                                  // R5
    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> evt_ref);                                            // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_ref && mode_q[4]));                                     // R7
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4 && wdata[1] && !match_pulse) |=> !evt_ref);   // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ref && !(wr_en && addr == 3'd4 && wdata[1])) |=> evt_ref);      // R8
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (cnt_q == '0));                                           // R10
    AST_OFF_CLEARS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && mode_q[0] && !wdata[0]) |=> (ref_q == '0)); // R11

endmodule

bind ref_timer rt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .irq         (irq),
    .mode_q      (mode_q),
    .ref_q       (ref_q),
    .cnt_q       (cnt_q),
    .evt_ref     (evt_ref),
    .tick        (tick),
    .match_pulse (match_pulse)
);

// File: tb/sim_ref_timer.sv
// Bench: a behavioural model steps on each rising edge. rdata and irq are
// compared with it late in every cycle.
module sim_ref_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    ref_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string tag = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    // Model state.
    logic [15:0] m_mode, m_ref, m_cnt, nc, nref;
    logic        m_evt, setf, en_m, run_m, tick_m, restart_m;
    logic [1:0]  src_m;
    int          ph = 0;
    int          divn;

    // Model step on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 16'h0; m_ref = 16'h0; m_cnt = 16'h0; m_evt = 1'b0; ph = 0;
        end else begin
            en_m      = m_mode[0];
            src_m     = m_mode[2:1];
            run_m     = en_m && (src_m == 2'd1 || src_m == 2'd2);
            restart_m = wr_en && (addr == 3'd0 || addr == 3'd1);
            divn      = (int'(m_mode[15:8]) + 1) * ((src_m == 2'd2) ? 16 : 1);
            tick_m    = 1'b0;
            if (!run_m || restart_m) ph = 0;
            else if (ph == divn - 1) begin tick_m = 1'b1; ph = 0; end
            else ph = ph + 1;
            nc = m_cnt; setf = 1'b0;
            if (!en_m || restart_m) nc = 16'h0;
            else if (wr_en && addr == 3'd3) nc = wdata;
            else if (tick_m) begin
                nc   = (m_mode[3] && m_cnt == m_ref) ? 16'h0 : m_cnt + 16'h1;
                setf = (nc == m_ref);
            end
            nref = m_ref;
            if (wr_en && addr == 3'd0 && m_mode[0] && !wdata[0]) nref = 16'h0;
            else if (wr_en && addr == 3'd1) nref = wdata;
            m_evt = (m_evt && !(wr_en && addr == 3'd4 && wdata[1])) || setf;
            if (wr_en && addr == 3'd0) m_mode = wdata;
            m_ref = nref;
            m_cnt = nc;
        end
        started = 1'b1;
        cyc = cyc + 1;
    end

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_ref;
            3'd3: return m_cnt;
            3'd4: return {14'h0, m_evt, 1'b0};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    // Late-cycle comparison against the model.
    always @(negedge clk) begin
        #4;
        if (started && !done) begin
            check($sformatf("rdata@%0d", addr), rdata, m_read(addr));
            check("irq", {15'h0, irq}, {15'h0, m_mode[4] && m_evt});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [2:0] after);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = after; wdata = 16'h0;
    endtask

    task automatic idle(input int n, input logic [2:0] a);
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    initial begin
        tag = "R1";
        idle(3, 3'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) idle(1, 3'(a));

        tag = "R2";                       // disabled: count held at zero
        wr(3'd0, 16'h0002, 3'd3);
        wr(3'd3, 16'h0055, 3'd3);
        idle(20, 3'd3);

        tag = "R3";                       // tick periods for both sources
        wr(3'd1, 16'hFFFF, 3'd3);
        wr(3'd0, 16'h0203, 3'd3);
        idle(40, 3'd3);
        wr(3'd0, 16'hFF03, 3'd3);
        idle(600, 3'd3);
        wr(3'd0, 16'h0005, 3'd3);
        idle(100, 3'd3);
        wr(3'd0, 16'h0105, 3'd3);
        idle(200, 3'd3);

        tag = "R4";                       // no tick source
        wr(3'd0, 16'h0001, 3'd3);
        idle(40, 3'd3);
        wr(3'd0, 16'h0007, 3'd3);
        idle(40, 3'd3);

        tag = "R5";                       // return to zero at reference
        wr(3'd1, 16'h0005, 3'd3);
        wr(3'd0, 16'h000B, 3'd3);
        idle(30, 3'd3);
        idle(10, 3'd4);

        tag = "R6";                       // no return: passes reference
        wr(3'd4, 16'h0002, 3'd4);
        wr(3'd0, 16'h0003, 3'd3);
        idle(20, 3'd3);
        idle(5, 3'd4);

        tag = "R7";                       // interrupt gating
        wr(3'd4, 16'h0002, 3'd4);
        wr(3'd0, 16'h001B, 3'd4);
        idle(20, 3'd4);
        wr(3'd0, 16'h000B, 3'd4);
        idle(5, 3'd4);

        tag = "R8";                       // write-one-to-clear
        wr(3'd0, 16'h0011, 3'd4);
        idle(3, 3'd4);
        wr(3'd4, 16'h0001, 3'd4);
        idle(3, 3'd4);
        wr(3'd4, 16'h0002, 3'd4);
        idle(3, 3'd4);

        tag = "R9";                       // count load while running
        wr(3'd1, 16'hFFFF, 3'd3);
        wr(3'd0, 16'h0303, 3'd3);
        idle(10, 3'd3);
        wr(3'd3, 16'h1234, 3'd3);
        idle(30, 3'd3);

        tag = "R10";                      // restart on control/reference write
        idle(2, 3'd3);
        wr(3'd1, 16'h0010, 3'd3);
        idle(20, 3'd3);
        wr(3'd0, 16'h0303, 3'd3);
        idle(10, 3'd3);

        tag = "R11";                      // switching off clears reference
        wr(3'd1, 16'h0077, 3'd1);
        wr(3'd0, 16'h0002, 3'd1);
        idle(3, 3'd1);
        wr(3'd1, 16'h0055, 3'd1);
        wr(3'd0, 16'h0000, 3'd1);
        idle(3, 3'd1);

        tag = "R12";                      // capture and unmapped addresses
        wr(3'd2, 16'hABCD, 3'd2);
        idle(2, 3'd2);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 16'hBEEF, 3'(a));
            idle(2, 3'(a));
        end
        idle(1, 3'd1);

        finish_run();
    end

endmodule